// File: doc/BRIEF.md
# Down-Spread Triangle Profile Generator

This block produces the frequency-offset profile that spreads the spectrum of one synthesized clock (nominally 37 MHz, made from a 27 MHz reference). Each cycle of the reference appears as a one-cycle `ref_tick` strobe. On every tick the block advances a symmetric triangular sweep. It outputs a signed fixed-point offset, in parts per million scaled by 2^FRAC_BITS, that a downstream fractional divider adds to its ratio. The offset is never positive, so the clock only moves down from nominal.

A 3-bit code picks the depth of the sweep. Four codes select a depth, and the other four mean no spread. A new code takes effect only on the tick where the sweep leaves zero offset, so a setting change never causes a frequency step in the middle of a sweep. When the clock's output enable is cleared, the block raises a power-down flag for its PLL, forces the offset to zero and restarts the sweep from zero.

The period is 2*HALF_STEPS ticks. With the defaults (27 MHz ticks, HALF_STEPS=386) the modulation rate is about 34.97 kHz, which lies inside the 30 to 40 kHz window.

Top module: `spread_profile_gen`

## Requirements
- R1: `offset_word` is never greater than zero.
- R2: Codes 3'b001, 3'b010, 3'b100 and 3'b110 select depths of 5000, 10000, 20000 and 30000 ppm. Per-tick increment inc = floor(ppm*2^FRAC_BITS/HALF_STEPS). Peak offset = -inc*HALF_STEPS.
- R3: Codes 3'b000, 3'b011, 3'b101 and 3'b111 hold `offset_word` at zero on every tick.
- R4: The k-th tick after the sweep leaves zero sets `offset_word` = -inc*t(k). Here m = k mod (2*HALF_STEPS), t(k)=m when m<=HALF_STEPS, and t(k)=2*HALF_STEPS-m otherwise. The period is 2*HALF_STEPS ticks.
- R5: `spread_code` is sampled only on a tick taken at zero offset position. A change made mid-sweep first shows on the tick after the sweep returns to zero.
- R6: One clock after `out_enable` is low, `pll_pd` is 1 and `offset_word` is 0. Ticks are ignored while `out_enable` is low, and the sweep restarts from zero. One clock after `out_enable` is high, `pll_pd` is 0.
- R7: After reset, `offset_word` is 0 and `pll_pd` is 0.
- R8: Without a tick, `offset_word` holds its value.
- R9: The offset is a two's-complement OFF_W-bit value in ppm times 2^FRAC_BITS, updated one clock after the tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| out_enable | input | 1 | Output enable of the spread clock |
| spread_code | input | 3 | Spread depth selection code |
| offset_word | output | OFF_W | Signed offset, ppm * 2^FRAC_BITS |
| pll_pd | output | 1 | Power-down request for the PLL |

## Verification
All results are registered, so each one is due one clock after the input that causes it. The offset moves on the edge that samples a tick. `pll_pd` and the forced zero follow one edge after the enable is sampled. The bench drives inputs on the falling edge, holds a tick high for exactly one rising edge, and compares on the next falling edge. It computes the expected triangle position from its own count of ticks since the sweep last left zero, and it tracks which code was latched at that point.

// File: rtl/spread_pkg.sv
package spread_pkg;

  // Depth in ppm selected by each spread code; unlisted codes mean no spread.
  function automatic int unsigned code_ppm(input logic [2:0] code);
    case (code)
      3'b001:  return 5000;
      3'b010:  return 10000;
      3'b100:  return 20000;
      3'b110:  return 30000;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sprd_code_lut.sv
module sprd_code_lut #(
  parameter int HALF_STEPS = 386,
  parameter int FRAC_BITS  = 8,
  parameter int INC_W      = 25
) (
  input  logic [2:0]       code_i,
  output logic [INC_W-1:0] inc_o
);
  import spread_pkg::*;

  logic [INC_W-1:0] tbl [8];

  // Per-tick increment for each code, computed at elaboration.
  for (genvar gi = 0; gi < 8; gi++) begin : g_entry
    localparam longint VAL = (longint'(code_ppm(3'(gi))) << FRAC_BITS) / HALF_STEPS;
    assign tbl[gi] = INC_W'(VAL);
  end

  assign inc_o = tbl[code_i];

endmodule

// File: rtl/sprd_tri_counter.sv
module sprd_tri_counter #(
  parameter int HALF_STEPS = 386,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] pos_nxt_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_STEPS);

  logic             up_q, up_d;
  logic [CNT_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    up_d  = up_q;
    if (clear_i) begin
      pos_d = '0;
      up_d  = 1'b1;
    end else if (step_i) begin
      if (up_q) begin
        pos_d = pos_q + 1'b1;
        up_d  = (pos_d != TOP);
      end else begin
        pos_d = pos_q - 1'b1;
        up_d  = (pos_d == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      up_q  <= 1'b1;
    end else begin
      pos_q <= pos_d;
      up_q  <= up_d;
    end
  end

  assign pos_o     = pos_q;
  assign pos_nxt_o = pos_d;

endmodule

// File: rtl/sprd_offset_reg.sv
module sprd_offset_reg #(
  parameter int OFF_W = 26,
  parameter int CNT_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear_i,
  input  logic [OFF_W-2:0]        inc_i,
  input  logic [CNT_W-1:0]        pos_i,
  output logic signed [OFF_W-1:0] offset_o
);
  localparam int MAG_W = OFF_W - 1;

  logic [MAG_W-1:0]        mag;
  logic signed [OFF_W-1:0] neg;

  assign mag = inc_i * MAG_W'(pos_i);
  assign neg = -$signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (rst || clear_i) offset_o <= '0;
    else                offset_o <= neg;
  end

endmodule

// File: rtl/spread_profile_gen.sv
module spread_profile_gen #(
  parameter int HALF_STEPS = 386,
  parameter int FRAC_BITS  = 8,
  parameter int OFF_W      = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_tick,
  input  logic                    out_enable,
  input  logic [2:0]              spread_code,
  output logic signed [OFF_W-1:0] offset_word,
  output logic                    pll_pd
);
  localparam int CNT_W = $clog2(HALF_STEPS + 1);
  localparam int INC_W = OFF_W - 1;

  logic             step, clear;
  logic [INC_W-1:0] lut_inc, inc_q, inc_d;
  logic [CNT_W-1:0] pos_q, pos_d;

  assign clear = ~out_enable;
  assign step  = ref_tick & out_enable;

  sprd_code_lut #(.HALF_STEPS(HALF_STEPS), .FRAC_BITS(FRAC_BITS), .INC_W(INC_W)) u_lut (
    .code_i (spread_code),
    .inc_o  (lut_inc)
  );

  sprd_tri_counter #(.HALF_STEPS(HALF_STEPS), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear),
    .step_i    (step),
    .pos_o     (pos_q),
    .pos_nxt_o (pos_d)
  );

  // Latch a new depth only on the tick that leaves zero offset.
  assign inc_d = (step && pos_q == '0) ? lut_inc : inc_q;

  always_ff @(posedge clk) begin
    if (rst) inc_q <= '0;
    else     inc_q <= inc_d;
  end

  sprd_offset_reg #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_off (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear),
    .inc_i    (inc_d),
    .pos_i    (pos_d),
    .offset_o (offset_word)
  );

  always_ff @(posedge clk) begin
    if (rst) pll_pd <= 1'b0;
    else     pll_pd <= clear;
  end

endmodule

// File: rtl/sprd_checker.sv
module sprd_checker #(
  parameter int HALF_STEPS = 386,
  parameter int FRAC_BITS  = 8,
  parameter int OFF_W      = 26
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ref_tick,
  input logic                    out_enable,
  input logic signed [OFF_W-1:0] offset_word,
  input logic                    pll_pd
);
  localparam longint PEAK_MAX =
    ((longint'(30000) << FRAC_BITS) / HALF_STEPS) * HALF_STEPS;

  assert_down_only_R1: assert property (@(posedge clk) disable iff (rst)
    !(offset_word > 0));

  assert_peak_bound_R2: assert property (@(posedge clk) disable iff (rst)
    longint'(offset_word) >= -PEAK_MAX);

  assert_pd_on_disable_R6: assert property (@(posedge clk) disable iff (rst)
    !out_enable |=> (pll_pd && offset_word == 0));

  assert_pd_off_enable_R6: assert property (@(posedge clk) disable iff (rst)
    out_enable |=> !pll_pd);

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (out_enable && !ref_tick) |=> $stable(offset_word));

endmodule

bind spread_profile_gen sprd_checker #(
  .HALF_STEPS(HALF_STEPS), .FRAC_BITS(FRAC_BITS), .OFF_W(OFF_W)
) u_sprd_checker (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .out_enable(out_enable),
  .offset_word(offset_word), .pll_pd(pll_pd)
);

// File: tb/test_spread_profile_gen.sv
module test_spread_profile_gen;
  localparam int H = 5;
  localparam int K = 4;
  localparam int W = 26;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ref_tick = 1'b0;
  logic               out_enable = 1'b1;
  logic [2:0]         spread_code = 3'b000;
  logic signed [W-1:0] offset_word;
  logic               pll_pd;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spread_profile_gen #(.HALF_STEPS(H), .FRAC_BITS(K), .OFF_W(W)) i_spread_profile_gen (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .out_enable(out_enable),
    .spread_code(spread_code), .offset_word(offset_word), .pll_pd(pll_pd)
  );

  function automatic longint depth_ppm(input logic [2:0] c);
    if (c == 3'b001) return 5000;
    if (c == 3'b010) return 10000;
    if (c == 3'b100) return 20000;
    if (c == 3'b110) return 30000;
    return 0;
  endfunction

  function automatic longint inc_of(input logic [2:0] c);
    return (depth_ppm(c) * (longint'(1) << K)) / H;
  endfunction

  function automatic longint tri_pos(input int k);
    int m = k % (2 * H);
    return (m <= H) ? m : 2 * H - m;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk) out_enable = 1'b0;
    @(negedge clk);
    chk("R6 pd", pll_pd, 1);
    chk("R6 zero", offset_word, 0);
    out_enable = 1'b1;
    @(negedge clk);
    chk("R6 pd release", pll_pd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 offset", offset_word, 0);
    chk("R7 pd", pll_pd, 0);

    // Full sweeps for every code.
    for (int c = 0; c < 8; c++) begin
      restart();
      spread_code = 3'(c);
      for (int k = 1; k <= 2 * H + 2; k++) begin
        tick();
        chk((depth_ppm(3'(c)) == 0) ? "R3 no spread" : "R4 triangle",
            offset_word, -inc_of(3'(c)) * tri_pos(k));
        chk("R1 down only", (offset_word > 0) ? 1 : 0, 0);
        if (k == H) chk("R2 peak", offset_word, -inc_of(3'(c)) * H);
        if (k == 3) begin
          repeat (3) @(negedge clk);
          chk("R8 hold", offset_word, -inc_of(3'(c)) * tri_pos(k));
        end
      end
    end

    // Code change mid-sweep takes effect after the return to zero.
    restart();
    spread_code = 3'b001;
    for (int k = 1; k <= 2 * H + 3; k++) begin
      if (k == 4) spread_code = 3'b110;
      tick();
      chk("R5 deferred code", offset_word,
          -((k <= 2 * H) ? inc_of(3'b001) : inc_of(3'b110)) * tri_pos(k));
    end

    // Disable mid-sweep: ticks ignored, restart from zero.
    restart();
    spread_code = 3'b100;
    repeat (3) tick();
    chk("R9 scale", offset_word, -((longint'(20000) << K) / H) * 3);
    @(negedge clk) out_enable = 1'b0;
    ref_tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ref_tick = 1'b0;
    chk("R6 ignore tick", offset_word, 0);
    chk("R6 pd mid", pll_pd, 1);
    out_enable = 1'b1;
    spread_code = 3'b010;
    tick();
    chk("R6 restart", offset_word, -inc_of(3'b010));
    chk("R6 pd low", pll_pd, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule